// File: doc/BRIEF.md
# Legacy Region Attribute Decoder

This block steers every access into the memory space below 1 MB either to main DRAM or to the expansion bus. Seven byte-wide attribute registers sit on a byte-addressed configuration port. Each register holds two independent four-bit fields. Each field has its own read enable and write enable for one segment of the legacy region. Some segments are 128 KB, some are 64 KB and some are 16 KB.

For each access the requester presents a 20-bit address, a write flag and a valid strobe. One clock later the block raises exactly one of two registered outputs. The claim output means DRAM serves the access. The forward output means the access goes out to the expansion bus. Two areas are never governed by a field. Low memory below 080000h always goes to DRAM. The 0A0000h–0BFFFFh hole always goes to the bus.

Top module: `legacy_attr_decoder`

## Requirements
- R1: The configuration port maps seven attribute registers at offsets 59h to 5Fh. A write to any of them is stored and reads back combinationally on `cfgRdData`. Any other offset reads 00h, and a write to it changes nothing.
- R2: Bits 2, 3, 6 and 7 of every attribute register are reserved. They read back as zero whatever was written.
- R3: After reset every attribute register holds 00h, so an access to any covered segment is forwarded.
- R4: In each nibble, bit 0 (bit 4 in the high nibble) lets reads go to DRAM and bit 1 (bit 5) lets writes go to DRAM. An access whose direction is not enabled is forwarded.
- R5: Register 59h: the low nibble governs 080000h–09FFFFh and the high nibble governs 0F0000h–0FFFFFh.
- R6: Registers 5Ah to 5Dh split 0C0000h–0DFFFFh into 16 KB segments in rising order, two per register. The low nibble governs the lower segment of each pair.
- R7: Registers 5Eh and 5Fh split 0E0000h–0EFFFFh into 16 KB segments with the same ordering and nibble rule as R6.
- R8: Accesses below 080000h are always claimed by DRAM. Accesses in 0A0000h–0BFFFFh are always forwarded. Neither depends on any register.
- R9: The outputs are registered. An access presented at a clock edge raises exactly one of `dramClaim` and `busForward` in the following cycle. A cycle with `accValid` low leaves both low in the next cycle.
- R10: An access in the same cycle as a configuration write to its register is decided with the register's old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Read data for the addressed offset |
| accValid | input | 1 | Access strobe |
| accAddr | input | 20 | Access address |
| accWrite | input | 1 | 1 = write access, 0 = read access |
| dramClaim | output | 1 | Access is served by DRAM (registered) |
| busForward | output | 1 | Access goes to the expansion bus (registered) |

## Verification
The assertions take for granted that `accAddr` is a full 20-bit legacy address, that `accWrite` is meaningful only while `accValid` is high, and that at most one configuration offset is addressed per cycle. The stimulus changes every input only on the falling clock edge. It keeps addresses inside the 1 MB window and lets `accValid` stay low for whole cycles, so the idle rule is exercised too. The random phase mixes configuration writes, including writes to offsets outside the map, with accesses in the same cycle.

// File: rtl/lad_pkg.sv
`timescale 1ns/1ps
package lad_pkg;
  localparam int NUM_REGS = 7;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrSel;
    logic [NUM_REGS-1:0] rdSel;
    logic                accStrobe;
    logic                accIsWrite;
  } ctlStrobes_t;
endpackage

// File: rtl/lad_ctrl.sv
`timescale 1ns/1ps
module lad_ctrl
  import lad_pkg::*;
#(
  parameter int CFG_AW   = 8,
  parameter int CFG_BASE = 'h59
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic              cfgWrEn,
  input  logic              accValid,
  input  logic              accWrite,
  output ctlStrobes_t       strobes
);
  logic [NUM_REGS-1:0] hitVec;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    localparam logic [CFG_AW-1:0] OFFS = CFG_AW'(CFG_BASE + i);
    assign hitVec[i] = (cfgAddr == OFFS);
  end

  always_comb begin
    strobes.wrSel      = hitVec & {NUM_REGS{cfgWrEn}};
    strobes.rdSel      = hitVec;
    strobes.accStrobe  = accValid;
    strobes.accIsWrite = accWrite;
  end

  // R1: a configuration write targets at most one register
  p_single_target_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.wrSel));
endmodule

// File: rtl/lad_datapath.sv
`timescale 1ns/1ps
module lad_datapath
  import lad_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int SEG_SHIFT = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [7:0]        cfgWrData,
  input  logic [ADDR_W-1:0] accAddr,
  output logic [7:0]        cfgRdData,
  output logic              dramClaim,
  output logic              busForward
);
  localparam logic [7:0] KEEP_MASK = 8'h33;
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int TOP = ADDR_W - 1;

  logic [7:0] attr [NUM_REGS];
  logic       covered, dfltClaim, useHi, claimNext;
  logic [IDX_W-1:0] regIdx;
  logic [3:0] nib;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_attr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  attr[i] <= '0;
      else if (strobes.wrSel[i])  attr[i] <= cfgWrData & KEEP_MASK;
    end
  end

  always_comb begin
    cfgRdData = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (strobes.rdSel[i]) cfgRdData = cfgRdData | attr[i];
  end

  // Region lookup on the top address bits
  always_comb begin
    covered   = 1'b0;
    dfltClaim = 1'b1;
    regIdx    = '0;
    useHi     = 1'b0;
    unique case (accAddr[TOP -: 3])
      3'b100: covered = 1'b1;
      3'b101: dfltClaim = 1'b0;
      3'b110: begin
        covered = 1'b1;
        regIdx  = IDX_W'(1) + IDX_W'(accAddr[SEG_SHIFT+2 -: 2]);
        useHi   = accAddr[SEG_SHIFT];
      end
      3'b111: begin
        covered = 1'b1;
        if (accAddr[TOP-3]) begin
          regIdx = '0;
          useHi  = 1'b1;
        end else begin
          regIdx = IDX_W'(5) + IDX_W'(accAddr[SEG_SHIFT+1]);
          useHi  = accAddr[SEG_SHIFT];
        end
      end
      default: ;
    endcase
    nib       = useHi ? attr[regIdx][7:4] : attr[regIdx][3:0];
    claimNext = covered ? (strobes.accIsWrite ? nib[1] : nib[0]) : dfltClaim;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dramClaim  <= 1'b0;
      busForward <= 1'b0;
    end else begin
      dramClaim  <= strobes.accStrobe &  claimNext;
      busForward <= strobes.accStrobe & ~claimNext;
    end
  end

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(dramClaim && busForward));
  p_one_answer_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accStrobe |=> $onehot({dramClaim, busForward}));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.accStrobe |=> (!dramClaim && !busForward));
  p_low_claim_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.accStrobe && !accAddr[TOP]) |=> dramClaim);
  p_hole_fwd_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.accStrobe && accAddr[TOP -: 3] == 3'b101) |=> busForward);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData & ~KEEP_MASK) == 8'h00);
endmodule

// File: rtl/legacy_attr_decoder.sv
`timescale 1ns/1ps
module legacy_attr_decoder
  import lad_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int CFG_AW   = 8,
  parameter int CFG_BASE = 'h59
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  output logic              dramClaim,
  output logic              busForward
);
  ctlStrobes_t strobes;

  lad_ctrl #(.CFG_AW(CFG_AW), .CFG_BASE(CFG_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWrEn(cfgWrEn),
    .accValid(accValid), .accWrite(accWrite), .strobes(strobes)
  );

  lad_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgWrData(cfgWrData),
    .accAddr(accAddr), .cfgRdData(cfgRdData),
    .dramClaim(dramClaim), .busForward(busForward)
  );
endmodule

// File: tb/sim_legacy_attr_decoder.sv
`timescale 1ns/1ps
module sim_legacy_attr_decoder;
  logic clk = 0, rstN = 0;
  logic [7:0] cfgAddr = 0, cfgWrData = 0, cfgRdData;
  logic cfgWrEn = 0, accValid = 0, accWrite = 0;
  logic [19:0] accAddr = 0;
  logic dramClaim, busForward;
  int tests = 0, fails = 0;
  bit [7:0] mreg [7];
  bit expC = 0, expF = 0;

  always #5 clk = ~clk;

  legacy_attr_decoder u0 (.*);

  function automatic bit modelClaim(int a, bit wr);
    int r, h, idx;
    bit [3:0] n;
    if (a < 'h80000) return 1;
    if (a >= 'hA0000 && a < 'hC0000) return 0;
    if (a < 'hA0000) begin r = 0; h = 0; end
    else if (a >= 'hF0000) begin r = 0; h = 1; end
    else if (a < 'hE0000) begin idx = (a - 'hC0000) / 'h4000; r = 1 + idx / 2; h = idx % 2; end
    else begin idx = (a - 'hE0000) / 'h4000; r = 5 + idx / 2; h = idx % 2; end
    n = h ? mreg[r][7:4] : mreg[r][3:0];
    return wr ? n[1] : n[0];
  endfunction

  // Reference model, updated on every clock
  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mreg[i]) mreg[i] = 0;
      expC <= 0; expF <= 0;
    end else begin
      expC <= accValid && modelClaim(int'(accAddr), accWrite);
      expF <= accValid && !modelClaim(int'(accAddr), accWrite);
      if (cfgWrEn && cfgAddr >= 8'h59 && cfgAddr <= 8'h5F)
        mreg[cfgAddr - 8'h59] <= cfgWrData & 8'h33;
    end
  end

  always @(negedge clk) if (rstN) begin
    tests++;
    if (dramClaim !== expC || busForward !== expF) begin
      fails++;
      $display("FAIL R9 model: claim/fwd=%b%b expected %b%b", dramClaim, busForward, expC, expF);
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(bit [7:0] off, bit [7:0] d);
    @(negedge clk); cfgAddr = off; cfgWrData = d; cfgWrEn = 1;
    @(negedge clk); cfgWrEn = 0;
  endtask

  task automatic cfgRead(bit [7:0] off, bit [7:0] exp, string tag);
    @(negedge clk); cfgAddr = off; #1;
    chk(cfgRdData === exp, tag, cfgRdData, exp);
  endtask

  task automatic access(int a, bit wr, bit expClaim, string tag);
    @(negedge clk); accAddr = 20'(a); accWrite = wr; accValid = 1;
    @(negedge clk); accValid = 0; #1;
    chk(dramClaim === expClaim && busForward === !expClaim, tag,
        {dramClaim, busForward}, {expClaim, !expClaim});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!dramClaim && !busForward, "R3 reset outputs", {dramClaim, busForward}, 0);
    rstN = 1;
    for (int o = 'h59; o <= 'h5F; o++) cfgRead(8'(o), 8'h00, "R3 reset value");
    access('h80000, 0, 0, "R3 covered forwarded");
    access('hD4000, 1, 0, "R3 covered forwarded");
    // R1 / R2
    cfgWrite(8'h59, 8'hFF);
    cfgRead(8'h59, 8'h33, "R2 reserved bits zero");
    cfgWrite(8'h58, 8'hFF);
    cfgRead(8'h58, 8'h00, "R1 unmapped reads zero");
    cfgWrite(8'h60, 8'hFF);
    cfgRead(8'h60, 8'h00, "R1 unmapped reads zero");
    cfgRead(8'h5A, 8'h00, "R1 unmapped write ignored");
    cfgRead(8'h59, 8'h33, "R1 stored value");
    access('h80000, 0, 1, "R5 low nibble read");
    access('h9FFFF, 1, 1, "R5 low nibble write");
    // R4 / R5 split enables
    cfgWrite(8'h59, 8'h21);
    access('h9FFFF, 0, 1, "R4 read enable");
    access('h9FFFF, 1, 0, "R4 write disabled");
    access('hF0000, 0, 0, "R5 high read disabled");
    access('hFFFFF, 1, 1, "R5 high write enabled");
    // R6
    cfgWrite(8'h5B, 8'h10);
    access('hCC000, 0, 1, "R6 upper segment of pair");
    access('hC8000, 0, 0, "R6 lower segment of pair");
    cfgWrite(8'h5D, 8'h02);
    access('hD8000, 1, 1, "R6 low nibble lower seg");
    access('hDC000, 1, 0, "R6 high nibble upper seg");
    access('hC0000, 0, 0, "R6 5Ah untouched");
    // R7
    cfgWrite(8'h5E, 8'h01);
    access('hE0000, 0, 1, "R7 5Eh low");
    access('hE4000, 0, 0, "R7 5Eh high");
    cfgWrite(8'h5F, 8'h30);
    access('hEC000, 1, 1, "R7 5Fh high write");
    access('hE8000, 0, 0, "R7 5Fh low");
    // R8
    for (int o = 'h59; o <= 'h5F; o++) cfgWrite(8'(o), 8'hFF);
    access('hA0000, 0, 0, "R8 hole forwarded");
    access('hBFFFF, 1, 0, "R8 hole forwarded");
    for (int o = 'h59; o <= 'h5F; o++) cfgWrite(8'(o), 8'h00);
    access('h7FFFF, 1, 1, "R8 low memory claimed");
    access('h00000, 0, 1, "R8 low memory claimed");
    // R9 idle
    @(negedge clk); accValid = 0; accAddr = 20'h00000;
    @(negedge clk); #1;
    chk(!dramClaim && !busForward, "R9 idle both low", {dramClaim, busForward}, 0);
    // R10 same-cycle write sees old value
    cfgWrite(8'h59, 8'h33);
    @(negedge clk); cfgAddr = 8'h59; cfgWrData = 8'h00; cfgWrEn = 1;
    accAddr = 20'h80000; accWrite = 0; accValid = 1;
    @(negedge clk); cfgWrEn = 0; accValid = 0; #1;
    chk(dramClaim === 1, "R10 old value used", dramClaim, 1);
    access('h80000, 0, 0, "R10 new value next");
    // Random mix compared against the model every clock
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      cfgWrEn   = ($urandom % 4) == 0;
      cfgAddr   = 8'('h57 + $urandom % 11);
      cfgWrData = 8'($urandom);
      accValid  = ($urandom % 5) != 0;
      accWrite  = 1'($urandom);
      accAddr   = 20'($urandom);
    end
    @(negedge clk); cfgWrEn = 0; accValid = 0;
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule